// File: doc/BRIEF.md
# Posted Write Drain Master

This block empties a queue of posted memory writes onto a bus where it acts as the initiator. Each write in the queue is one address entry followed by one or more data words. The last data word carries an end-of-write mark. The engine takes the address entry and raises a bus request. After it sees the grant, it drives one address phase and then data phases. It moves one word per clock for as long as the target accepts and the queue has words. A word leaves the queue only when the target takes it.

A burst ends when the final word of the write is accepted, or when the queue has no word after the current one. It also ends when the target signals stop, or when the latency count has run out after the grant has been taken away. When a burst ends early, the engine starts a follow-on burst later, at the address of the first word the target has not taken. A target abort ends the write: every word of it still queued is popped and dropped. The engine then reports the abort with the number of dropped words. A write that completes is reported as delivered.

The queue side is a valid/ready stream. The engine pops the head entry in a cycle where `q_valid` and `q_ready` are both high. While `q_valid` is high and `q_ready` is low, the queue must hold the head entry and its flags stable. The queue also provides `q_more`, which is high when at least one entry waits behind the head. The bus pins, the target response pins and the status pins are plain, with no handshake.

Top module: `pwf_master`

## Requirements
- R1: While reset is held, `bus_req`, `bus_frame`, `bus_irdy`, `q_ready` and `done_valid` are all low.
- R2: An address phase has `bus_frame` high, `bus_irdy` low and `bus_ad` equal to the write's current address. It happens only in the cycle after `bus_gnt` was seen high while a data word was queued.
- R3: The first data phase is in the clock right after the address phase. While the target asserts `tgt_trdy`, one word is popped every clock with no idle master cycle. A word is popped on the bus only when the target takes it.
- R4: `bus_frame` is low during the final data phase of a burst. A phase is final when its word has `q_last` set, when `q_more` is low, or when the latency count is zero while `bus_gnt` is low. Once a phase is final, it stays final.
- R5: When the word marked `q_last` is accepted, `done_valid` pulses for exactly one cycle, one clock later, with `done_abort` = 0 and `done_discards` = 0.
- R6: A disconnect is `tgt_stop` together with `tgt_trdy`. On a disconnect the current word is accepted and the burst ends. A follow-on burst then starts at the start address + 4 × the number of words already accepted.
- R7: A retry is `tgt_stop` without `tgt_trdy`. On a retry no word is popped and the burst ends. A retry on the first phase restarts at the original address, and every word is still delivered.
- R8: `tgt_abort` ends the write. The phase's word and all later words of that write are popped and not driven on the bus. `done_valid` then pulses with `done_abort` = 1 and `done_discards` equal to the number of dropped words. A following write in the queue is left intact.
- R9: The latency count loads `lat_init` in the address phase and counts down by one in each data cycle. With `lat_init` = 2 and the grant removed after the address phase, the burst ends after 3 words. The rest of the write follows in a second burst.
- R10: When the queue runs dry in the middle of a write, the burst ends with no completion reported. When more words of that write arrive, a follow-on burst continues at the next address.
- R11: At least one cycle with `bus_frame` and `bus_irdy` both low separates the end of a burst from the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_valid | input | 1 | Head entry of the queue is present |
| q_ready | output | 1 | Head entry is popped this cycle |
| q_data | input | DW | Address (for an address entry) or data word |
| q_is_addr | input | 1 | Head entry is an address entry |
| q_last | input | 1 | Head data word is the final word of its write |
| q_more | input | 1 | At least one more entry waits behind the head |
| lat_init | input | LTW | Latency count loaded at each address phase |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_frame | output | 1 | Transaction active, low on the final data phase |
| bus_irdy | output | 1 | Master data phase |
| bus_ad | output | DW | Address in the address phase, data in data phases |
| tgt_trdy | input | 1 | Target takes the word |
| tgt_stop | input | 1 | Target asks to end the burst |
| tgt_abort | input | 1 | Target aborts the write |
| done_valid | output | 1 | One-cycle pulse when a write finishes |
| done_abort | output | 1 | Finished write was aborted |
| done_discards | output | CW | Number of words dropped on abort |

## Verification
A plain write with the target always ready shows one address phase and back-to-back data. Target wait states show that the engine holds its word without popping. A first-phase retry restarts at the original address, while a mid-burst disconnect restarts at an advanced address; comparing the two confirms that the follow-on address counts accepted words only. A queue that runs dry mid-write, and a grant removed under a short latency count, each split one write into two bursts without a completion between them. An abort with a second write queued behind it shows that the flush stops exactly at the write boundary and reports the right drop count.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_DATA,
    ST_TURN,
    ST_FLUSH
  } pwf_state_e;
endpackage

// File: rtl/pwf_lat_timer.sv
module pwf_lat_timer #(
  parameter int LTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           run,
  input  logic [LTW-1:0] init,
  output logic           zero
);
  logic [LTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= init;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwf_addr_track.sv
module pwf_addr_track #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [DW-1:0] base,
  output logic [DW-1:0] addr
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (adv)  addr <= addr + STEP;
  end
endmodule

// File: rtl/pwf_fsm.sv
module pwf_fsm
  import pwf_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid,
  input  logic          q_is_addr,
  input  logic          q_last,
  input  logic          q_more,
  input  logic          bus_gnt,
  input  logic          tgt_trdy,
  input  logic          tgt_stop,
  input  logic          tgt_abort,
  input  logic          lat_zero,
  output logic          q_ready,
  output logic          bus_req,
  output logic          bus_frame,
  output logic          bus_irdy,
  output logic          sel_addr,
  output logic          addr_load,
  output logic          addr_adv,
  output logic          lat_load,
  output logic          lat_run,
  output logic          done_valid,
  output logic          done_abort,
  output logic [CW-1:0] done_discards
);
  pwf_state_e st, st_nx;
  logic open_wr, last_hold;
  logic [CW-1:0] drop_cnt;

  logic in_data, abort_hit, accept, stop_hit, ph_last, end_xfer, wr_done;
  logic flush_pop, flush_end, addr_pop;

  assign in_data   = (st == ST_DATA);
  assign abort_hit = in_data && tgt_abort;
  assign accept    = in_data && tgt_trdy && !tgt_abort;
  assign stop_hit  = in_data && tgt_stop && !tgt_abort;
  assign ph_last   = last_hold || q_last || !q_more || (lat_zero && !bus_gnt);
  assign end_xfer  = stop_hit || (accept && ph_last);
  assign wr_done   = accept && q_last;
  assign flush_pop = (st == ST_FLUSH) && q_valid;
  assign flush_end = flush_pop && q_last;
  assign addr_pop  = (st == ST_IDLE) && q_valid && q_is_addr;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (addr_pop) st_nx = ST_ARB;
      ST_ARB:   if (q_valid && bus_gnt) st_nx = ST_ADDR;
      ST_ADDR:  st_nx = ST_DATA;
      ST_DATA: begin
        if (abort_hit)     st_nx = ST_FLUSH;
        else if (end_xfer) st_nx = ST_TURN;
      end
      ST_TURN:  st_nx = open_wr ? ST_ARB : ST_IDLE;
      ST_FLUSH: if (flush_end) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      open_wr       <= 1'b0;
      last_hold     <= 1'b0;
      drop_cnt      <= '0;
      done_valid    <= 1'b0;
      done_abort    <= 1'b0;
      done_discards <= '0;
    end else begin
      st <= st_nx;
      if (addr_pop)                  open_wr <= 1'b1;
      else if (wr_done || flush_end) open_wr <= 1'b0;
      last_hold <= in_data && ph_last && !end_xfer && !abort_hit;
      if (abort_hit)      drop_cnt <= '0;
      else if (flush_pop) drop_cnt <= drop_cnt + 1'b1;
      done_valid    <= wr_done || flush_end;
      done_abort    <= flush_end;
      done_discards <= flush_end ? drop_cnt + 1'b1 : '0;
    end
  end

  assign q_ready   = addr_pop || accept || flush_pop;
  assign bus_req   = ((st == ST_ARB) && q_valid) || (st == ST_ADDR) || (in_data && !ph_last);
  assign bus_frame = (st == ST_ADDR) || (in_data && !ph_last);
  assign bus_irdy  = in_data;
  assign sel_addr  = (st == ST_ADDR);
  assign addr_load = addr_pop;
  assign addr_adv  = accept;
  assign lat_load  = (st == ST_ADDR);
  assign lat_run   = in_data;
endmodule

// File: rtl/pwf_master.sv
module pwf_master #(
  parameter int DW  = 32,
  parameter int LTW = 8,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           q_valid,
  output logic           q_ready,
  input  logic [DW-1:0]  q_data,
  input  logic           q_is_addr,
  input  logic           q_last,
  input  logic           q_more,
  input  logic [LTW-1:0] lat_init,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_frame,
  output logic           bus_irdy,
  output logic [DW-1:0]  bus_ad,
  input  logic           tgt_trdy,
  input  logic           tgt_stop,
  input  logic           tgt_abort,
  output logic           done_valid,
  output logic           done_abort,
  output logic [CW-1:0]  done_discards
);
  logic sel_addr, addr_load, addr_adv, lat_load, lat_run, lat_zero;
  logic [DW-1:0] cur_addr;

  pwf_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .q_valid(q_valid), .q_is_addr(q_is_addr), .q_last(q_last), .q_more(q_more),
    .bus_gnt(bus_gnt), .tgt_trdy(tgt_trdy), .tgt_stop(tgt_stop), .tgt_abort(tgt_abort),
    .lat_zero(lat_zero),
    .q_ready(q_ready), .bus_req(bus_req), .bus_frame(bus_frame), .bus_irdy(bus_irdy),
    .sel_addr(sel_addr), .addr_load(addr_load), .addr_adv(addr_adv),
    .lat_load(lat_load), .lat_run(lat_run),
    .done_valid(done_valid), .done_abort(done_abort), .done_discards(done_discards)
  );

  pwf_addr_track #(.DW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .adv(addr_adv),
    .base(q_data), .addr(cur_addr)
  );

  pwf_lat_timer #(.LTW(LTW)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(lat_load), .run(lat_run),
    .init(lat_init), .zero(lat_zero)
  );

  assign bus_ad = sel_addr ? cur_addr : (bus_irdy ? q_data : '0);
endmodule

// File: rtl/pwf_master_chk.sv
module pwf_master_chk (
  input logic clk,
  input logic rst_n,
  input logic q_ready,
  input logic bus_gnt,
  input logic bus_frame,
  input logic bus_irdy,
  input logic tgt_trdy,
  input logic tgt_stop,
  input logic tgt_abort,
  input logic lat_zero,
  input logic done_valid
);
  // R2: an address phase follows a cycle in which the grant was high
  p_grant_before_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frame && !bus_irdy) |-> $past(bus_gnt));

  // R3: data phase directly after the address phase
  p_data_follows_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frame && !bus_irdy) |=> bus_irdy);

  // R3: a word leaves the queue during a data phase only when the target takes it
  p_pop_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && q_ready) |-> (tgt_trdy && !tgt_abort));

  // R4: expired count with no grant makes the phase final
  p_timer_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && lat_zero && !bus_gnt) |-> !bus_frame);

  // R5: completion report is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R11: a finished final phase is followed by an idle bus cycle
  p_idle_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && !bus_frame && (tgt_trdy || tgt_stop || tgt_abort)) |=> (!bus_irdy && !bus_frame));
endmodule

bind pwf_master pwf_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .q_ready(q_ready), .bus_gnt(bus_gnt),
  .bus_frame(bus_frame), .bus_irdy(bus_irdy), .tgt_trdy(tgt_trdy),
  .tgt_stop(tgt_stop), .tgt_abort(tgt_abort), .lat_zero(lat_zero),
  .done_valid(done_valid)
);

// File: tb/pwf_master_test.sv
module pwf_master_test;
  localparam int ACK = 0, WAITST = 1, DISC = 2, RETRY = 3, ABORT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic q_valid = 1'b0, q_is_addr = 1'b0, q_last = 1'b0, q_more = 1'b0;
  logic [31:0] q_data = '0;
  logic [7:0] lat_init = 8'd255;
  logic bus_gnt = 1'b0, tgt_trdy = 1'b0, tgt_stop = 1'b0, tgt_abort = 1'b0;
  logic q_ready, bus_req, bus_frame, bus_irdy, done_valid, done_abort;
  logic [31:0] bus_ad;
  logic [7:0] done_discards;

  pwf_master uut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data),
    .q_is_addr(q_is_addr), .q_last(q_last), .q_more(q_more), .lat_init(lat_init),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_frame(bus_frame), .bus_irdy(bus_irdy),
    .bus_ad(bus_ad), .tgt_trdy(tgt_trdy), .tgt_stop(tgt_stop), .tgt_abort(tgt_abort),
    .done_valid(done_valid), .done_abort(done_abort), .done_discards(done_discards)
  );

  int checks = 0, errors = 0;
  logic [33:0] fifo[$];
  int resp[$];
  logic [63:0] exp_q[$];
  logic [8:0] exp_done[$];
  logic [31:0] wr_addr = '0, cur_start = '0;
  int idx = 0, nphase = 0, cycles = 0;
  bit prev_ready = 0, prev_irdy = 0, want_data = 0, gnt_en = 1, drop_gnt = 0, done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void push_addr(input logic [31:0] a);
    fifo.push_back({2'b10, a});
    wr_addr = a;
  endfunction

  function automatic void push_data(input logic [31:0] d, input bit last, input bit keep);
    fifo.push_back({1'b0, last, d});
    if (keep) exp_q.push_back({wr_addr, d});
    wr_addr += 4;
  endfunction

  // bus model and monitor
  always @(negedge clk) begin
    int code;
    cycles++;
    if (prev_ready && fifo.size() > 0) void'(fifo.pop_front());
    if (fifo.size() > 0) begin
      {q_is_addr, q_last, q_data} = fifo[0];
      q_valid = 1'b1;
    end else begin
      {q_is_addr, q_last, q_data} = '0;
      q_valid = 1'b0;
    end
    q_more = fifo.size() > 1;
    code = (resp.size() > 0) ? resp[0] : ACK;
    tgt_trdy  = (code == ACK) || (code == DISC);
    tgt_stop  = (code == DISC) || (code == RETRY);
    tgt_abort = (code == ABORT);
    bus_gnt   = gnt_en;
    #1;
    if (rst_n) begin
      if (bus_frame && !bus_irdy) begin
        chk(!prev_irdy, "R11 idle cycle before address phase", 32'(prev_irdy), 0);
        cur_start = bus_ad;
        idx = 0;
        nphase++;
        want_data = 1;
        if (drop_gnt) begin gnt_en = 0; drop_gnt = 0; end
      end else if (want_data) begin
        chk(bus_irdy, "R3 data phase after address phase", 32'(bus_irdy), 1);
        want_data = 0;
      end
      if (bus_irdy) begin
        if (q_last) chk(!bus_frame, "R4 frame low on final word", 32'(bus_frame), 0);
        if (tgt_trdy && !tgt_abort) begin
          if (exp_q.size() == 0) chk(0, "R6 unexpected word", bus_ad, 0);
          else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk(cur_start + 32'(4 * idx) == e[63:32], "R6 R7 word address", cur_start + 32'(4 * idx), e[63:32]);
            chk(bus_ad == e[31:0], "R3 word data", bus_ad, e[31:0]);
          end
          idx++;
        end
        if (resp.size() > 0) void'(resp.pop_front());
      end else if (!gnt_en && !bus_frame) gnt_en = 1;
      if (done_valid) begin
        if (exp_done.size() == 0) chk(0, "R5 unexpected completion", {done_abort, done_discards}, 0);
        else begin
          logic [8:0] d;
          d = exp_done.pop_front();
          chk({done_abort, done_discards} == d, "R5 R8 completion status", {done_abort, done_discards}, d);
        end
      end
    end
    prev_ready = q_ready;
    prev_irdy  = bus_irdy;
    if (cycles > 20000 && !done) begin
      done = 1;
      chk(0, "watchdog expired", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic at_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (n < 4) begin
      @(negedge clk);
      #2;
      if (fifo.size() == 0 && exp_q.size() == 0 && exp_done.size() == 0 && !bus_frame && !bus_irdy) n++;
      else n = 0;
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      #2;
      chk({bus_req, bus_frame, bus_irdy, q_ready, done_valid} == 0, "R1 reset outputs",
          {bus_req, bus_frame, bus_irdy, q_ready, done_valid}, 0);
    end
    at_edge();
    rst_n = 1'b1;

    // plain write, target always ready
    at_edge();
    nphase = 0;
    push_addr(32'h1000);
    for (int i = 0; i < 4; i++) push_data(32'hA000 + i, i == 3, 1);
    exp_done.push_back(9'h000);
    wait_idle();
    chk(nphase == 1, "R2 single burst", nphase, 1);

    // retry on first phase
    at_edge();
    nphase = 0;
    resp.push_back(RETRY);
    push_addr(32'h2000);
    for (int i = 0; i < 3; i++) push_data(32'hB000 + i, i == 2, 1);
    exp_done.push_back(9'h000);
    wait_idle();
    chk(nphase == 2, "R7 retry restarts", nphase, 2);

    // disconnect after two words
    at_edge();
    nphase = 0;
    resp.push_back(ACK);
    resp.push_back(DISC);
    push_addr(32'h3000);
    for (int i = 0; i < 5; i++) push_data(32'hC000 + i, i == 4, 1);
    exp_done.push_back(9'h000);
    wait_idle();
    chk(nphase == 2, "R6 disconnect restarts", nphase, 2);

    // target wait states
    at_edge();
    nphase = 0;
    resp.push_back(WAITST); resp.push_back(ACK); resp.push_back(WAITST); resp.push_back(WAITST);
    push_addr(32'h4000);
    for (int i = 0; i < 3; i++) push_data(32'hD000 + i, i == 2, 1);
    exp_done.push_back(9'h000);
    wait_idle();
    chk(nphase == 1, "R3 wait states keep one burst", nphase, 1);

    // queue runs dry mid-write
    at_edge();
    nphase = 0;
    push_addr(32'h5000);
    push_data(32'hE000, 0, 1);
    push_data(32'hE001, 0, 1);
    repeat (12) at_edge();
    chk(exp_q.size() == 0, "R10 words before stall delivered", exp_q.size(), 0);
    chk(!bus_frame && !bus_irdy, "R10 bus released while dry", {bus_frame, bus_irdy}, 0);
    chk(nphase == 1, "R10 one burst so far", nphase, 1);
    push_data(32'hE002, 0, 1);
    push_data(32'hE003, 1, 1);
    exp_done.push_back(9'h000);
    wait_idle();
    chk(nphase == 2, "R10 follow-on burst", nphase, 2);

    // latency count expiry with grant removed
    at_edge();
    nphase = 0;
    lat_init = 8'd2;
    drop_gnt = 1;
    push_addr(32'h6000);
    for (int i = 0; i < 6; i++) push_data(32'hF000 + i, i == 5, 1);
    exp_done.push_back(9'h000);
    wait_idle();
    chk(nphase == 2, "R9 timer splits burst", nphase, 2);
    lat_init = 8'd255;

    // abort with another write queued behind
    at_edge();
    nphase = 0;
    resp.push_back(ACK);
    resp.push_back(ABORT);
    push_addr(32'h7000);
    push_data(32'h7700, 0, 1);
    push_data(32'h7701, 0, 0);
    push_data(32'h7702, 0, 0);
    push_data(32'h7703, 1, 0);
    exp_done.push_back({1'b1, 8'd3});
    push_addr(32'h8000);
    push_data(32'h8800, 0, 1);
    push_data(32'h8801, 1, 1);
    exp_done.push_back(9'h000);
    wait_idle();
    chk(nphase == 2, "R8 next write after abort", nphase, 2);

    chk(exp_q.size() == 0 && exp_done.size() == 0, "R5 all results seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule